// File: doc/BRIEF.md
# Packet Commit Buffer

The block gathers every side effect that the instructions of one VLIW packet produce and releases them together when the packet commits. While the packet runs, execution units log register writes, predicate writes, taken branches and up to two stores (one per store slot), and can cancel slots through a mask. Nothing leaves the block until the commit strobe. Then register and predicate write enables and the next PC come out in a single cycle, and the surviving stores are replayed on a simple memory write port, slot 0 first.

Three rules set it apart from a plain write log. Repeated writes to one predicate within a packet are merged by bitwise AND. Only the first taken branch counts. A load issued in slot 0 while slot 1 holds a live store forces that store out to memory at once, ahead of the load, and the store is then not replayed at commit.

Top module: `pcb_commit_buffer`

## Requirements
- R1: After reset, `rf_we`, `pr_we`, `npc_we`, `mem_we` and `commit_done` are all low.
- R2: In the cycle after an accepted commit, `rf_we` has a bit set for exactly the registers written in the packet, and the matching `rf_wdata` slice holds the last value written to that register.
- R3: The first write to a predicate in a packet keeps the low 8 bits of `pred_wr_data`. Each later write to the same predicate ANDs its low 8 bits into the held value. `pr_we` marks exactly the written predicates, in the same cycle as `rf_we`.
- R4: Only the first `br_taken` target of a packet is kept, and later ones are ignored. In the cycle after commit, `npc_we` is high exactly when a branch was taken, with `npc` equal to that first target.
- R5: A store is logged only when its size code (a byte count) is 1, 2, 4 or 8. Any other code leaves the slot unchanged. `mem_data` carries the low 8×size bits of the logged data, and the bits above are zero.
- R6: A store whose slot bit is set in the accumulated cancel mask (bit 0 is slot 0, bit 1 is slot 1) is not written at commit or early.
- R7: A `load_slot0` pulse while slot 1 holds a logged, uncancelled store that has not yet gone out produces a memory write of that store in the next cycle, and that store is not written again at commit.
- R8: With commit accepted at clock edge E, the register, predicate and PC pulses and the slot-0 store appear in the cycle after E. The slot-1 store follows one cycle later, and `commit_done` pulses one cycle after that.
- R9: `pkt_start` discards every logged item of the packet: register and predicate flags, the branch, both stores and the cancel mask.
- R10: A commit also clears the branch flag, predicate-written flags, cancel mask and stores. A following packet's first predicate write stores directly, and its first branch is accepted.
- R11: A commit request that arrives while a commit sequence is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Discard logged state, begin a new packet |
| reg_wr_en | input | 1 | Register write log strobe |
| reg_wr_idx | input | $clog2(NUM_REGS) | Register index |
| reg_wr_data | input | DATA_W | Register value |
| pred_wr_en | input | 1 | Predicate write log strobe |
| pred_wr_idx | input | $clog2(NUM_PREDS) | Predicate index |
| pred_wr_data | input | DATA_W | Predicate value, low 8 bits used |
| br_taken | input | 1 | Taken branch report |
| br_target | input | ADDR_W | Branch target |
| st_log_en | input | 1 | Store log strobe |
| st_log_slot | input | 1 | Store slot (0 or 1) |
| st_log_addr | input | ADDR_W | Store address |
| st_log_size | input | 4 | Store size in bytes |
| st_log_data | input | 64 | Store data |
| cancel_en | input | 1 | Cancel mask strobe |
| cancel_mask | input | 2 | Slots to cancel, ORed into held mask |
| load_slot0 | input | 1 | Slot-0 load is about to read memory |
| commit | input | 1 | Commit request |
| rf_we | output | NUM_REGS | Register file write enables |
| rf_wdata | output | NUM_REGS*DATA_W | Register file write data, slice i for register i |
| pr_we | output | NUM_PREDS | Predicate write enables |
| pr_wdata | output | NUM_PREDS*8 | Predicate write data |
| npc_we | output | 1 | Next-PC write enable |
| npc | output | ADDR_W | Next PC |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_size | output | 4 | Memory write size in bytes |
| mem_data | output | 64 | Memory write data |
| commit_done | output | 1 | Commit sequence finished |

## Verification
The bench builds the block with eight registers, four predicates and 32-bit data and addresses. With so few registers and predicates, random packets often write the same register or predicate twice, which exercises last-write-wins and AND merging on nearly every run. The two store slots, partial cancel masks and random slot-0 loads then cover early store issue combined with cancellation, before or after the load, across many packets. Illegal size codes, doubled branches, a commit held high through the sequence, and a packet discarded by `pkt_start` are driven as directed cases.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int PRED_W    = 8;
  localparam int SIZE_W    = 4;
  localparam int ST_DATA_W = 64;
  localparam int NUM_SLOTS = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SLOT0 = 2'd1,
    SEQ_SLOT1 = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;

  // store size is a byte count; only naturally sized accesses are legal
  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction

  function automatic logic [ST_DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    logic [ST_DATA_W-1:0] m;
    case (sz)
      4'd1:    m = 64'h0000_0000_0000_00FF;
      4'd2:    m = 64'h0000_0000_0000_FFFF;
      4'd4:    m = 64'h0000_0000_FFFF_FFFF;
      4'd8:    m = 64'hFFFF_FFFF_FFFF_FFFF;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pcb_reg_stage.sv
module pcb_reg_stage #(
  parameter  int NUM_REGS = 16,
  parameter  int DATA_W   = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         commit,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS-1:0]          we_out,
  output logic [NUM_REGS*DATA_W-1:0]   data_out
);

  logic [NUM_REGS-1:0] written_vec;
  logic [NUM_REGS-1:0] we_d, we_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              hit;
    logic              wr_d, wr_q;
    logic [DATA_W-1:0] val_q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      wr_d = wr_q;
      if (clear || commit) wr_d = 1'b0;
      else if (hit)        wr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= wr_d;
    end

    // data staging carries no reset; it is qualified by the written flag
    always_ff @(posedge clk) begin
      if (hit) val_q <= wr_data;
    end

    assign written_vec[g]                  = wr_q;
    assign data_out[g*DATA_W +: DATA_W]    = val_q;
  end

  always_comb begin
    we_d = '0;
    if (commit) we_d = written_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= '0;
    else        we_q <= we_d;
  end

  assign we_out = we_q;

endmodule

// File: rtl/pcb_pred_stage.sv
module pcb_pred_stage
  import pcb_pkg::*;
#(
  parameter  int NUM_PREDS = 4,
  parameter  int DATA_W    = 32,
  localparam int IDX_W     = $clog2(NUM_PREDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          commit,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_PREDS-1:0]          we_out,
  output logic [NUM_PREDS*PRED_W-1:0]   data_out
);

  logic [NUM_PREDS-1:0] written_vec;
  logic [NUM_PREDS-1:0] we_d, we_q;
  logic [PRED_W-1:0]    wr_byte;

  assign wr_byte = wr_data[PRED_W-1:0];

  for (genvar g = 0; g < NUM_PREDS; g++) begin : g_pred
    logic              hit;
    logic              wr_d, wr_q;
    logic [PRED_W-1:0] val_d, val_q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      wr_d  = wr_q;
      val_d = val_q;
      if (clear || commit) begin
        wr_d = 1'b0;
      end else if (hit) begin
        wr_d  = 1'b1;
        // repeated writes within a packet merge by AND
        val_d = wr_q ? (val_q & wr_byte) : wr_byte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= wr_d;
    end

    always_ff @(posedge clk) begin
      if (hit && !clear && !commit) val_q <= val_d;
    end

    assign written_vec[g]                  = wr_q;
    assign data_out[g*PRED_W +: PRED_W]    = val_q;
  end

  always_comb begin
    we_d = '0;
    if (commit) we_d = written_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= '0;
    else        we_q <= we_d;
  end

  assign we_out = we_q;

endmodule

// File: rtl/pcb_store_log.sv
module pcb_store_log
  import pcb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   commit,
  input  logic                   st_en,
  input  logic                   st_slot,
  input  logic [ADDR_W-1:0]      st_addr,
  input  logic [SIZE_W-1:0]      st_size,
  input  logic [ST_DATA_W-1:0]   st_data,
  input  logic                   cancel_en,
  input  logic [NUM_SLOTS-1:0]   cancel_mask,
  input  logic                   load_slot0,
  output logic                   busy,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [SIZE_W-1:0]      mem_size,
  output logic [ST_DATA_W-1:0]   mem_data,
  output logic                   done
);

  logic [NUM_SLOTS-1:0] vld_vec;
  logic [ADDR_W-1:0]    addr_arr [NUM_SLOTS];
  logic [SIZE_W-1:0]    size_arr [NUM_SLOTS];
  logic [ST_DATA_W-1:0] data_arr [NUM_SLOTS];

  logic                 flush;
  assign flush = clear || commit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic                 take;
    logic                 v_d, v_q;
    logic [ADDR_W-1:0]    a_q;
    logic [SIZE_W-1:0]    z_q;
    logic [ST_DATA_W-1:0] d_q;

    assign take = st_en && (st_slot == 1'(s)) && size_legal(st_size) && !flush;

    always_comb begin
      v_d = v_q;
      if (flush)     v_d = 1'b0;
      else if (take) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        a_q <= st_addr;
        z_q <= st_size;
        d_q <= st_data & size_mask(st_size);
      end
    end

    assign vld_vec[s]  = v_q;
    assign addr_arr[s] = a_q;
    assign size_arr[s] = z_q;
    assign data_arr[s] = d_q;
  end

  // cancel mask, early-issue bookkeeping and drain sequencer
  seq_state_e           state_q, state_d;
  logic [NUM_SLOTS-1:0] cancel_q, cancel_d;
  logic                 early_q, early_d;
  logic                 early_go_q;
  logic                 early_fire;
  logic                 live0_q, live1_q;
  logic                 live0_d, live1_d;

  assign early_fire = load_slot0 && (state_q == SEQ_IDLE) && !flush &&
                      vld_vec[1] && !cancel_q[1] && !early_q;

  always_comb begin
    cancel_d = cancel_q;
    early_d  = early_q;
    if (flush) begin
      cancel_d = '0;
      early_d  = 1'b0;
    end else begin
      if (cancel_en)  cancel_d = cancel_q | cancel_mask;
      if (early_fire) early_d  = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    live0_d = live0_q;
    live1_d = live1_q;
    case (state_q)
      SEQ_IDLE: begin
        if (commit) begin
          state_d = SEQ_SLOT0;
          live0_d = vld_vec[0] && !cancel_q[0];
          live1_d = vld_vec[1] && !cancel_q[1] && !early_q;
        end
      end
      SEQ_SLOT0: state_d = SEQ_SLOT1;
      SEQ_SLOT1: state_d = SEQ_DONE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cancel_q   <= '0;
      early_q    <= 1'b0;
      early_go_q <= 1'b0;
      live0_q    <= 1'b0;
      live1_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cancel_q   <= cancel_d;
      early_q    <= early_d;
      early_go_q <= early_fire;
      live0_q    <= live0_d;
      live1_q    <= live1_d;
    end
  end

  logic sel1;

  always_comb begin
    mem_we = 1'b0;
    sel1   = 1'b0;
    if (early_go_q) begin
      mem_we = 1'b1;
      sel1   = 1'b1;
    end else if (state_q == SEQ_SLOT0) begin
      mem_we = live0_q;
    end else if (state_q == SEQ_SLOT1) begin
      mem_we = live1_q;
      sel1   = 1'b1;
    end
  end

  assign mem_addr = sel1 ? addr_arr[1] : addr_arr[0];
  assign mem_size = sel1 ? size_arr[1] : size_arr[0];
  assign mem_data = sel1 ? data_arr[1] : data_arr[0];
  assign busy     = (state_q != SEQ_IDLE);
  assign done     = (state_q == SEQ_DONE);

endmodule

// File: rtl/pcb_commit_buffer.sv
module pcb_commit_buffer
  import pcb_pkg::*;
#(
  parameter  int NUM_REGS  = 16,
  parameter  int NUM_PREDS = 4,
  parameter  int DATA_W    = 32,
  parameter  int ADDR_W    = 32,
  localparam int RIDX_W    = $clog2(NUM_REGS),
  localparam int PIDX_W    = $clog2(NUM_PREDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pkt_start,
  input  logic                          reg_wr_en,
  input  logic [RIDX_W-1:0]             reg_wr_idx,
  input  logic [DATA_W-1:0]             reg_wr_data,
  input  logic                          pred_wr_en,
  input  logic [PIDX_W-1:0]             pred_wr_idx,
  input  logic [DATA_W-1:0]             pred_wr_data,
  input  logic                          br_taken,
  input  logic [ADDR_W-1:0]             br_target,
  input  logic                          st_log_en,
  input  logic                          st_log_slot,
  input  logic [ADDR_W-1:0]             st_log_addr,
  input  logic [3:0]                    st_log_size,
  input  logic [63:0]                   st_log_data,
  input  logic                          cancel_en,
  input  logic [1:0]                    cancel_mask,
  input  logic                          load_slot0,
  input  logic                          commit,
  output logic [NUM_REGS-1:0]           rf_we,
  output logic [NUM_REGS*DATA_W-1:0]    rf_wdata,
  output logic [NUM_PREDS-1:0]          pr_we,
  output logic [NUM_PREDS*8-1:0]        pr_wdata,
  output logic                          npc_we,
  output logic [ADDR_W-1:0]             npc,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [3:0]                    mem_size,
  output logic [63:0]                   mem_data,
  output logic                          commit_done
);

  logic busy;
  logic commit_go;

  // a commit is taken only when no sequence is running; pkt_start wins
  assign commit_go = commit && !busy && !pkt_start;

  pcb_reg_stage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_reg_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pkt_start),
    .commit   (commit_go),
    .wr_en    (reg_wr_en),
    .wr_idx   (reg_wr_idx),
    .wr_data  (reg_wr_data),
    .we_out   (rf_we),
    .data_out (rf_wdata)
  );

  pcb_pred_stage #(.NUM_PREDS(NUM_PREDS), .DATA_W(DATA_W)) i_pred_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pkt_start),
    .commit   (commit_go),
    .wr_en    (pred_wr_en),
    .wr_idx   (pred_wr_idx),
    .wr_data  (pred_wr_data),
    .we_out   (pr_we),
    .data_out (pr_wdata)
  );

  pcb_store_log #(.ADDR_W(ADDR_W)) i_store_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (pkt_start),
    .commit      (commit_go),
    .st_en       (st_log_en),
    .st_slot     (st_log_slot),
    .st_addr     (st_log_addr),
    .st_size     (st_log_size),
    .st_data     (st_log_data),
    .cancel_en   (cancel_en),
    .cancel_mask (cancel_mask),
    .load_slot0  (load_slot0),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_data    (mem_data),
    .done        (commit_done)
  );

  // first-taken-branch capture
  logic              taken_q, taken_d;
  logic              tgt_en;
  logic [ADDR_W-1:0] tgt_q;
  logic              npc_we_q;

  assign tgt_en = br_taken && !taken_q && !pkt_start && !commit_go;

  always_comb begin
    taken_d = taken_q;
    if (pkt_start || commit_go) taken_d = 1'b0;
    else if (br_taken)          taken_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      npc_we_q <= 1'b0;
    end else begin
      taken_q  <= taken_d;
      npc_we_q <= commit_go && taken_q;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt_en) tgt_q <= br_target;
  end

  assign npc_we = npc_we_q;
  assign npc    = tgt_q;

endmodule

// File: rtl/pcb_commit_buffer_chk.sv
module pcb_commit_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit_go,
  input logic        rf_any,
  input logic        pr_any,
  input logic        npc_we,
  input logic        mem_we,
  input logic [3:0]  mem_size,
  input logic [63:0] mem_data,
  input logic        commit_done
);

  AST_RF_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_any |-> $past(commit_go)); // R2

  AST_PRED_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pr_any |-> $past(commit_go)); // R3

  AST_NPC_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    npc_we |-> $past(commit_go)); // R4

  AST_STORE_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_size == 4'd1 || mem_size == 4'd2 || mem_size == 4'd4 || mem_size == 4'd8)); // R5

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_size != 4'd8) |-> (mem_data[63:32] == 32'h0)); // R5

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> $past(commit_go, 3)); // R8

  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> !commit_go); // R11

  AST_NO_REENTRY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit_go, 2) |-> !commit_go); // R11

endmodule

bind pcb_commit_buffer pcb_commit_buffer_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit_go   (commit_go),
  .rf_any      (|rf_we),
  .pr_any      (|pr_we),
  .npc_we      (npc_we),
  .mem_we      (mem_we),
  .mem_size    (mem_size),
  .mem_data    (mem_data),
  .commit_done (commit_done)
);

// File: tb/test_pcb_commit_buffer.sv
`timescale 1ns/1ps
module test_pcb_commit_buffer;

  localparam int NR = 8;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int AW = 32;

  logic              clk;
  logic              rst_n;
  logic              pkt_start;
  logic              reg_wr_en;
  logic [2:0]        reg_wr_idx;
  logic [DW-1:0]     reg_wr_data;
  logic              pred_wr_en;
  logic [1:0]        pred_wr_idx;
  logic [DW-1:0]     pred_wr_data;
  logic              br_taken;
  logic [AW-1:0]     br_target;
  logic              st_log_en;
  logic              st_log_slot;
  logic [AW-1:0]     st_log_addr;
  logic [3:0]        st_log_size;
  logic [63:0]       st_log_data;
  logic              cancel_en;
  logic [1:0]        cancel_mask;
  logic              load_slot0;
  logic              commit;
  logic [NR-1:0]     rf_we;
  logic [NR*DW-1:0]  rf_wdata;
  logic [NP-1:0]     pr_we;
  logic [NP*8-1:0]   pr_wdata;
  logic              npc_we;
  logic [AW-1:0]     npc;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [3:0]        mem_size;
  logic [63:0]       mem_data;
  logic              commit_done;

  pcb_commit_buffer #(.NUM_REGS(NR), .NUM_PREDS(NP), .DATA_W(DW), .ADDR_W(AW)) i_pcb_commit_buffer (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .pred_wr_en(pred_wr_en), .pred_wr_idx(pred_wr_idx), .pred_wr_data(pred_wr_data),
    .br_taken(br_taken), .br_target(br_target),
    .st_log_en(st_log_en), .st_log_slot(st_log_slot), .st_log_addr(st_log_addr),
    .st_log_size(st_log_size), .st_log_data(st_log_data),
    .cancel_en(cancel_en), .cancel_mask(cancel_mask), .load_slot0(load_slot0),
    .commit(commit),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .pr_we(pr_we), .pr_wdata(pr_wdata),
    .npc_we(npc_we), .npc(npc),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data),
    .commit_done(commit_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  // bench model of the packet
  logic [DW-1:0] m_reg  [NR];
  bit            m_rw   [NR];
  logic [7:0]    m_pred [NP];
  bit            m_pw   [NP];
  bit            m_br;
  logic [AW-1:0] m_tgt;
  bit            s_v [2];
  logic [AW-1:0] s_a [2];
  logic [3:0]    s_z [2];
  logic [63:0]   s_d [2];
  bit            canc [2];
  bit            early1;

  function automatic logic [63:0] smask(input logic [3:0] sz);
    case (sz)
      4'd1: return 64'hFF;
      4'd2: return 64'hFFFF;
      4'd4: return 64'hFFFF_FFFF;
      4'd8: return '1;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NR; i++) m_rw[i] = 1'b0;
    for (int i = 0; i < NP; i++) m_pw[i] = 1'b0;
    m_br = 1'b0;
    for (int s = 0; s < 2; s++) begin s_v[s] = 1'b0; canc[s] = 1'b0; end
    early1 = 1'b0;
  endtask

  task automatic op_pkt();
    pkt_start = 1'b1; step(); pkt_start = 1'b0;
    clear_model();
  endtask

  task automatic op_reg(input int idx, input logic [DW-1:0] d);
    reg_wr_en = 1'b1; reg_wr_idx = 3'(idx); reg_wr_data = d;
    step(); reg_wr_en = 1'b0;
    m_reg[idx] = d; m_rw[idx] = 1'b1;
  endtask

  task automatic op_pred(input int idx, input logic [DW-1:0] d);
    pred_wr_en = 1'b1; pred_wr_idx = 2'(idx); pred_wr_data = d;
    step(); pred_wr_en = 1'b0;
    if (m_pw[idx]) m_pred[idx] = m_pred[idx] & d[7:0];
    else           m_pred[idx] = d[7:0];
    m_pw[idx] = 1'b1;
  endtask

  task automatic op_br(input logic [AW-1:0] t);
    br_taken = 1'b1; br_target = t;
    step(); br_taken = 1'b0;
    if (!m_br) begin m_br = 1'b1; m_tgt = t; end
  endtask

  task automatic op_store(input int slot, input logic [AW-1:0] a, input logic [3:0] z, input logic [63:0] d);
    st_log_en = 1'b1; st_log_slot = 1'(slot); st_log_addr = a; st_log_size = z; st_log_data = d;
    step(); st_log_en = 1'b0;
    if (z == 4'd1 || z == 4'd2 || z == 4'd4 || z == 4'd8) begin
      s_v[slot] = 1'b1; s_a[slot] = a; s_z[slot] = z; s_d[slot] = d & smask(z);
    end
  endtask

  task automatic op_cancel(input logic [1:0] m);
    cancel_en = 1'b1; cancel_mask = m;
    step(); cancel_en = 1'b0;
    if (m[0]) canc[0] = 1'b1;
    if (m[1]) canc[1] = 1'b1;
  endtask

  task automatic chk_store(input int slot, input string req);
    chk(mem_addr == s_a[slot], req, 64'(mem_addr), 64'(s_a[slot]));
    chk(mem_size == s_z[slot], req, 64'(mem_size), 64'(s_z[slot]));
    chk(mem_data == s_d[slot], req, mem_data, s_d[slot]);
  endtask

  task automatic op_load();
    bit exp;
    exp = s_v[1] && !canc[1] && !early1;
    load_slot0 = 1'b1;
    step(); load_slot0 = 1'b0;
    chk(mem_we == exp, "R7 early store strobe", 64'(mem_we), 64'(exp));
    if (exp) chk_store(1, "R7 early store fields");
    if (exp) early1 = 1'b1;
  endtask

  task automatic commit_check();
    logic [NR-1:0] erw;
    logic [NP-1:0] epw;
    bit e0, e1;
    for (int i = 0; i < NR; i++) erw[i] = m_rw[i];
    for (int i = 0; i < NP; i++) epw[i] = m_pw[i];
    e0 = s_v[0] && !canc[0];
    e1 = s_v[1] && !canc[1] && !early1;
    commit = 1'b1; step(); commit = 1'b0;
    chk(rf_we == erw, "R2 register enables", 64'(rf_we), 64'(erw));
    for (int i = 0; i < NR; i++)
      if (m_rw[i]) chk(rf_wdata[i*DW +: DW] == m_reg[i], "R2 register data", 64'(rf_wdata[i*DW +: DW]), 64'(m_reg[i]));
    chk(pr_we == epw, "R3 predicate enables", 64'(pr_we), 64'(epw));
    for (int i = 0; i < NP; i++)
      if (m_pw[i]) chk(pr_wdata[i*8 +: 8] == m_pred[i], "R3 predicate AND data", 64'(pr_wdata[i*8 +: 8]), 64'(m_pred[i]));
    chk(npc_we == m_br, "R4 npc enable", 64'(npc_we), 64'(m_br));
    if (m_br) chk(npc == m_tgt, "R4 first branch target", 64'(npc), 64'(m_tgt));
    chk(mem_we == e0, "R6/R8 slot0 commit write", 64'(mem_we), 64'(e0));
    if (e0) chk_store(0, "R5 slot0 store fields");
    chk(commit_done == 1'b0, "R8 done not early", 64'(commit_done), 64'(0));
    step();
    chk(mem_we == e1, "R6/R7/R8 slot1 commit write", 64'(mem_we), 64'(e1));
    if (e1) chk_store(1, "R5 slot1 store fields");
    chk(rf_we == '0, "R8 single register pulse", 64'(rf_we), 64'(0));
    step();
    chk(commit_done == 1'b1, "R8 done pulse", 64'(commit_done), 64'(1));
    chk(mem_we == 1'b0, "R8 no write with done", 64'(mem_we), 64'(0));
    step();
    chk(commit_done == 1'b0, "R8 done single cycle", 64'(commit_done), 64'(0));
    clear_model();
  endtask

  function automatic logic [3:0] rand_size();
    int r;
    r = int'($urandom % 10);
    if (r < 3) return 4'd8;
    if (r < 5) return 4'd4;
    if (r < 7) return 4'd2;
    if (r < 9) return 4'd1;
    return (($urandom % 2) == 0) ? 4'd3 : 4'd0;
  endfunction

  task automatic random_packet();
    int n;
    op_pkt();
    n = 2 + int'($urandom % 10);
    for (int k = 0; k < n; k++) begin
      case ($urandom % 6)
        0: op_reg(int'($urandom % NR), $urandom);
        1: op_pred(int'($urandom % NP), $urandom);
        2: op_br($urandom);
        3: op_store(int'($urandom % 2), $urandom, rand_size(), {$urandom, $urandom});
        4: if (($urandom % 3) == 0) op_cancel(2'($urandom)); else op_reg(int'($urandom % NR), $urandom);
        default: op_load();
      endcase
    end
    commit_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; pkt_start = 0; reg_wr_en = 0; reg_wr_idx = 0; reg_wr_data = 0;
    pred_wr_en = 0; pred_wr_idx = 0; pred_wr_data = 0; br_taken = 0; br_target = 0;
    st_log_en = 0; st_log_slot = 0; st_log_addr = 0; st_log_size = 0; st_log_data = 0;
    cancel_en = 0; cancel_mask = 0; load_slot0 = 0; commit = 0;
    clear_model();
    repeat (3) step();
    // R1 reset state
    chk(rf_we == '0, "R1 rf_we after reset", 64'(rf_we), 64'(0));
    chk(pr_we == '0, "R1 pr_we after reset", 64'(pr_we), 64'(0));
    chk(npc_we == 1'b0, "R1 npc_we after reset", 64'(npc_we), 64'(0));
    chk(mem_we == 1'b0, "R1 mem_we after reset", 64'(mem_we), 64'(0));
    chk(commit_done == 1'b0, "R1 done after reset", 64'(commit_done), 64'(0));
    rst_n = 1'b1;
    step();

    // R3: high bits dropped, second write ANDs
    op_pkt();
    op_pred(1, 32'hABCD_12F3);
    op_pred(1, 32'h0000_003C);
    op_reg(2, 32'h1111_2222);
    op_reg(2, 32'h3333_4444);
    commit_check();

    // R4: two branches, first kept
    op_pkt();
    op_br(32'h0000_1000);
    op_br(32'h0000_2000);
    commit_check();

    // R5: illegal size leaves slot empty; narrow data masked
    op_pkt();
    op_store(0, 32'h40, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    op_store(1, 32'h80, 4'd2, 64'h1234_5678_9ABC_DEF0);
    commit_check();

    // R6: both slots cancelled
    op_pkt();
    op_store(0, 32'h100, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD);
    op_store(1, 32'h104, 4'd8, 64'h0102_0304_0506_0708);
    op_cancel(2'b11);
    commit_check();

    // R7: early issue, no replay at commit; cancelled slot1 never issued
    op_pkt();
    op_store(0, 32'h200, 4'd1, 64'h55);
    op_store(1, 32'h208, 4'd8, 64'hDEAD_BEEF_0BAD_F00D);
    op_load();
    op_load();
    commit_check();
    op_pkt();
    op_store(1, 32'h300, 4'd4, 64'h7777_8888);
    op_cancel(2'b10);
    op_load();
    commit_check();

    // R9: pkt_start discards everything logged
    op_pkt();
    op_reg(5, 32'hCAFE_0005);
    op_pred(3, 32'h77);
    op_br(32'h0000_5000);
    op_store(0, 32'h500, 4'd4, 64'h5555);
    op_cancel(2'b01);
    op_pkt();
    commit_check();

    // R10: commit clears flags without pkt_start
    op_pkt();
    op_pred(0, 32'hF0);
    op_br(32'h0000_0100);
    commit_check();
    op_pred(0, 32'h0F);
    op_br(32'h0000_0200);
    commit_check();

    // R11: commit held high through the sequence
    op_pkt();
    op_reg(4, 32'h4444_0004);
    m_reg[4] = 32'h4444_0004;
    commit = 1'b1; step();
    chk(rf_we == 8'h10, "R11 first commit accepted", 64'(rf_we), 64'h10);
    step();
    chk(rf_we == '0, "R11 held commit ignored", 64'(rf_we), 64'(0));
    step();
    chk(commit_done == 1'b1, "R11 done while held", 64'(commit_done), 64'(1));
    commit = 1'b0; step();
    chk(rf_we == '0 && mem_we == 1'b0 && commit_done == 1'b0, "R11 no second sequence",
        64'({rf_we, mem_we, commit_done}), 64'(0));
    clear_model();

    for (int p = 0; p < 80; p++) random_packet();

    ended = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule